// File: doc/BRIEF.md
# Dual-CPU Interrupt Controller with Shadow Masks

This block collects forty level-sensitive interrupt lines and turns them into one interrupt request per processor thread (CPU0 and CPU1). Software reaches it through a small 32-bit register bus. There is an enable (mask) register and a pending register for each of two banks: the low bank holds lines 0 to 31 and the high bank holds lines 32 to 39.

An ordinary line reaches exactly one CPU. The integration parameters choose which one, and CPU0 is the default. A line that both CPUs must see on their own terms is paired at build time with a spare line, called its shadow. The line's own enable bit then gates what CPU0 sees, and the shadow's enable bit gates what CPU1 sees. The shadow line never acts as a source: its input level is ignored and its pending bit reads zero.

Each request output is a registered OR of the enabled lines routed to that CPU. It follows the line levels one clock later and stays high for as long as any such line stays high.

Top module: `shadow_irq_ctrl`

## Requirements
- R1: After reset every enable bit reads 0 and both request outputs are 0, even when all source lines are high.
- R2: The low enable register at offset 0x04 is fully readable and writable. Bit n enables line n for n in 0..31, and a 1 means enabled.
- R3: The high enable register at offset 0x50 holds bits 7:0, where bit n enables line 32+n. Bits 31:8 ignore writes and read 0.
- R4: The pending registers read (line level AND enabling mask). The low bank is at 0x08 and the high bank at 0x54, using the same bit layout as the enable registers. Any other offset reads 0.
- R5: Writes to the pending offsets, or to any offset that is not mapped, leave both enable registers unchanged.
- R6: An unpaired enabled line raises CPU0's request, or only CPU1's request when its bit in the routing parameter is 1. It never raises both. The default routing sends lines 8 and 35 to CPU1.
- R7: For a paired line, its own enable bit gates CPU0's request and the shadow's enable bit gates CPU1's request. Its pending bit is set when either gated view is active. The default pairs are line 30 with shadow 29 and line 39 with shadow 33.
- R8: A shadow line's input level never raises a request and never sets a pending bit, whatever the enable bits hold.
- R9: A request output rises on the first clock edge after an enabled line goes high. It stays high while the line stays high, and it falls on the first edge after the last such line goes low.
- R10: Read data is registered. It takes the value of the addressed register on the clock edge that samples the read, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 40 | Level interrupt lines, bit n is line n |
| bus_sel_i | input | 1 | Bus access request this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Request per CPU, bit 0 for CPU0 and bit 1 for CPU1 |

## Verification
A corrupted enable bit shows at the ports in two ways. The next read of the enable or pending offset returns a wrong value, and the request output of the CPU that line feeds is wrong one edge after the line is driven. A wrong pairing or routing decision shows up as a request on the wrong CPU, or as a request caused by a shadow line, one cycle after that line goes high. For this reason the bench drives every line class (unpaired on each CPU, paired with each gate, shadow) separately and checks both outputs together with the pending readback. The timing checks sample the request just before and just after the edge where it should change, so a missing or extra register stage stands out.

// File: rtl/shadow_irq_pkg.sv
package shadow_irq_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned IDX_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h54;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MASK_LO,
    ACC_MASK_HI,
    ACC_PEND_LO,
    ACC_PEND_HI
  } acc_e;

  function automatic acc_e decode_acc(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_MASK_LO: return ACC_MASK_LO;
      OFS_MASK_HI: return ACC_MASK_HI;
      OFS_PEND_LO: return ACC_PEND_LO;
      OFS_PEND_HI: return ACC_PEND_HI;
      default:     return ACC_NONE;
    endcase
  endfunction

  // Clear every bit of v at position w and above.
  function automatic logic [BUS_W-1:0] keep_low(input logic [BUS_W-1:0] v,
                                                input int unsigned w);
    logic [BUS_W-1:0] r;
    for (int unsigned b = 0; b < BUS_W; b++) r[b] = (b < w) ? v[b] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/shadow_irq_regs.sv
module shadow_irq_regs
  import shadow_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  input  logic [NUM_SRC-1:0]  pend_i,
  output logic [NUM_SRC-1:0]  mask_o,
  output logic [BUS_W-1:0]    rdata_o
);
  localparam int unsigned HI_W = NUM_SRC - BUS_W;

  acc_e               acc;
  logic [NUM_SRC-1:0] mask_q;
  logic [BUS_W-1:0]   rd_word;
  logic               wr_evt;
  logic               rd_evt;
  logic               wr_ignored_evt;

  assign acc            = decode_acc(addr_i);
  assign wr_evt         = sel_i && wr_i;
  assign rd_evt         = sel_i && !wr_i;
  assign wr_ignored_evt = wr_evt && (acc != ACC_MASK_LO) && (acc != ACC_MASK_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_evt) begin
      if (acc == ACC_MASK_LO) mask_q[BUS_W-1:0] <= wdata_i;
      if (acc == ACC_MASK_HI) mask_q[NUM_SRC-1:BUS_W] <= wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    case (acc)
      ACC_MASK_LO: rd_word = mask_q[BUS_W-1:0];
      ACC_MASK_HI: rd_word = keep_low(BUS_W'(mask_q >> BUS_W), HI_W);
      ACC_PEND_LO: rd_word = pend_i[BUS_W-1:0];
      ACC_PEND_HI: rd_word = keep_low(BUS_W'(pend_i >> BUS_W), HI_W);
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_o <= '0;
    else if (rd_evt) rdata_o <= rd_word;
  end

  assign mask_o = mask_q;

  AST_IGNORED_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored_evt |=> $stable(mask_q)); // R5
  AST_NO_ACCESS_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rdata_o)); // R10
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && acc == ACC_MASK_HI) |=> (rdata_o[BUS_W-1:HI_W] == '0)); // R3
endmodule

// File: rtl/shadow_irq_route.sv
module shadow_irq_route
  import shadow_irq_pkg::*;
#(
  parameter int unsigned              NUM_SRC    = 40,
  parameter int unsigned              NUM_PAIRS  = 2,
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_TGT = {8'd39, 8'd30},
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_SHD = {8'd33, 8'd29},
  parameter logic [NUM_SRC-1:0]       ROUTE_CPU1 = 40'h08_0000_0100
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] cpu0_o,
  output logic [NUM_SRC-1:0] cpu1_o,
  output logic [NUM_SRC-1:0] pend_o
);
  // Shadow line of a paired line, or -1 for a line that is not paired.
  function automatic int shadow_of(input int line);
    for (int p = 0; p < int'(NUM_PAIRS); p++)
      if (int'(PAIR_TGT[p*IDX_W +: IDX_W]) == line)
        return int'(PAIR_SHD[p*IDX_W +: IDX_W]);
    return -1;
  endfunction

  function automatic bit is_shadow(input int line);
    for (int p = 0; p < int'(NUM_PAIRS); p++)
      if (int'(PAIR_SHD[p*IDX_W +: IDX_W]) == line) return 1'b1;
    return 1'b0;
  endfunction

  for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_line
    localparam int PARTNER = shadow_of(i);
    localparam bit SHD     = is_shadow(i);
    if (SHD) begin : g_shd
      logic unused_shadow_lvl;
      assign unused_shadow_lvl = src_i[i];
      assign cpu0_o[i] = 1'b0;
      assign cpu1_o[i] = 1'b0;
      assign pend_o[i] = 1'b0;
    end else if (PARTNER >= 0) begin : g_pair
      assign cpu0_o[i] = src_i[i] & mask_i[i];
      assign cpu1_o[i] = src_i[i] & mask_i[PARTNER];
      assign pend_o[i] = cpu0_o[i] | cpu1_o[i];
    end else begin : g_single
      logic en;
      assign en        = src_i[i] & mask_i[i];
      assign cpu0_o[i] = en & ~ROUTE_CPU1[i];
      assign cpu1_o[i] = en &  ROUTE_CPU1[i];
      assign pend_o[i] = en;
    end
  end
endmodule

// File: rtl/shadow_irq_out.sv
module shadow_irq_out #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cpu0_i,
  input  logic [NUM_SRC-1:0] cpu1_i,
  output logic [1:0]         irq_o
);
  logic [1:0] any_now;

  assign any_now = {|cpu1_i, |cpu0_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= any_now;
  end
endmodule

// File: rtl/shadow_irq_ctrl.sv
module shadow_irq_ctrl
  import shadow_irq_pkg::*;
#(
  parameter int unsigned                NUM_SRC    = 40,
  parameter int unsigned                NUM_PAIRS  = 2,
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_TGT   = {8'd39, 8'd30},
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_SHD   = {8'd33, 8'd29},
  parameter logic [NUM_SRC-1:0]         ROUTE_CPU1 = 40'h08_0000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic [1:0]         irq_o
);
  function automatic logic [NUM_SRC-1:0] shadow_set();
    logic [NUM_SRC-1:0] r;
    r = '0;
    for (int p = 0; p < int'(NUM_PAIRS); p++) r[PAIR_SHD[p*IDX_W +: IDX_W]] = 1'b1;
    return r;
  endfunction

  localparam logic [NUM_SRC-1:0] SHADOW_LINES = shadow_set();

  logic [NUM_SRC-1:0] mask_w;
  logic [NUM_SRC-1:0] pend_w;
  logic [NUM_SRC-1:0] cpu0_w;
  logic [NUM_SRC-1:0] cpu1_w;
  logic               none_pending;
  logic               only_shadow_lvl;

  shadow_irq_regs #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .pend_i  (pend_w),
    .mask_o  (mask_w),
    .rdata_o (bus_rdata_o)
  );

  shadow_irq_route #(
    .NUM_SRC    (NUM_SRC),
    .NUM_PAIRS  (NUM_PAIRS),
    .PAIR_TGT   (PAIR_TGT),
    .PAIR_SHD   (PAIR_SHD),
    .ROUTE_CPU1 (ROUTE_CPU1)
  ) route_i (
    .src_i  (src_i),
    .mask_i (mask_w),
    .cpu0_o (cpu0_w),
    .cpu1_o (cpu1_w),
    .pend_o (pend_w)
  );

  shadow_irq_out #(.NUM_SRC(NUM_SRC)) out_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu0_i (cpu0_w),
    .cpu1_i (cpu1_w),
    .irq_o  (irq_o)
  );

  assign none_pending    = (pend_w == '0);
  assign only_shadow_lvl = ((src_i & ~SHADOW_LINES) == '0);

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    none_pending |=> (irq_o == 2'b00)); // R9
  AST_PENDING_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !none_pending |=> (irq_o != 2'b00)); // R9
  AST_SHADOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    only_shadow_lvl |=> (irq_o == 2'b00)); // R8
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |=> (irq_o == 2'b00)); // R1
endmodule

// File: tb/shadow_irq_ctrl_tb_top.sv
module shadow_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // Columns: low enable, high enable, line levels, expected {cpu1,cpu0}, pending low, pending high
  localparam int NV = 12;
  localparam logic [31:0] V_MLO [NV] = '{32'h1, 32'h100, 32'hFFFF_FFFF, 32'h2000_0000,
    32'h4000_0000, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_00F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_MHI [NV] = '{32'h0, 32'h0, 32'hFF, 32'h0, 32'h0, 32'h80, 32'h02,
    32'h08, 32'hFF, 32'h0, 32'hFF, 32'hFF};
  localparam logic [39:0] V_SRC [NV] = '{40'h1, 40'h100, 40'h00_2000_0000, 40'h00_4000_0000,
    40'h00_4000_0000, 40'h80_0000_0000, 40'h80_0000_0000, 40'h08_0000_0000, 40'h0,
    40'hFF_FFFF_FF0F, 40'h02_0000_0000, 40'h40_0000_0000};
  localparam logic [1:0]  V_IRQ [NV] = '{2'b01, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 2'b10,
    2'b10, 2'b00, 2'b00, 2'b00, 2'b01};
  localparam logic [31:0] V_PLO [NV] = '{32'h1, 32'h100, 32'h0, 32'h4000_0000, 32'h4000_0000,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_PHI [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h80, 32'h80,
    32'h08, 32'h0, 32'h0, 32'h0, 32'h40};

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] q);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    q = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    src = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", 40'(irq), 40'h0);
    bus_read(8'h04, q); check("R1 low enable after reset", 40'(q), 40'h0);
    bus_read(8'h50, q); check("R1 high enable after reset", 40'(q), 40'h0);
    src = '0;

    // R2 / R3 readback
    bus_write(8'h04, 32'hA5C3_0F96);
    bus_read(8'h04, q); check("R2 low enable readback", 40'(q), 40'hA5C3_0F96);
    bus_write(8'h50, 32'hFFFF_FF5A);
    bus_read(8'h50, q); check("R3 high enable readback", 40'(q), 40'h5A);

    // R4 unmapped offsets read zero
    bus_read(8'h0C, q); check("R4 unmapped 0x0C", 40'(q), 40'h0);
    bus_read(8'h00, q); check("R4 unmapped 0x00", 40'(q), 40'h0);

    // R5 writes to pending or unmapped offsets are ignored
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h54, 32'hFFFF_FFFF);
    bus_write(8'h60, 32'h0);
    bus_read(8'h04, q); check("R5 low enable kept", 40'(q), 40'hA5C3_0F96);
    bus_read(8'h50, q); check("R5 high enable kept", 40'(q), 40'h5A);

    // R10 read data holds until the sampling edge
    bus_read(8'h04, q);
    sel = 1'b1; wr = 1'b0; addr = 8'h50;
    #1 check("R10 rdata before edge", 40'(rdata), 40'hA5C3_0F96);
    @(negedge clk);
    sel = 1'b0;
    check("R10 rdata after edge", 40'(rdata), 40'h5A);

    // Vector table: R4 pending, R6 routing, R7 pairs, R8 shadows
    for (int v = 0; v < NV; v++) begin
      bus_write(8'h04, V_MLO[v]);
      bus_write(8'h50, V_MHI[v]);
      src = V_SRC[v];
      @(negedge clk);
      check($sformatf("R6 R7 R8 irq vector %0d", v), 40'(irq), 40'(V_IRQ[v]));
      bus_read(8'h08, q); check($sformatf("R4 R7 pending low vector %0d", v), 40'(q), 40'(V_PLO[v]));
      bus_read(8'h54, q); check($sformatf("R4 R8 pending high vector %0d", v), 40'(q), 40'(V_PHI[v]));
      src = '0;
      @(negedge clk);
    end

    // R6: routed line 8 alone with everything enabled reaches only CPU1
    bus_write(8'h04, 32'hFFFF_FFFF);
    src = 40'h100;
    @(negedge clk);
    check("R6 line 8 only on CPU1", 40'(irq), 40'h2);
    src = '0;

    // R9 timing of request output
    bus_write(8'h04, 32'h1);
    bus_write(8'h50, 32'h0);
    @(negedge clk);
    src = 40'h1;
    #1 check("R9 no request before edge", 40'(irq), 40'h0);
    @(negedge clk);
    check("R9 request after one edge", 40'(irq), 40'h1);
    repeat (3) @(negedge clk);
    check("R9 request held while high", 40'(irq), 40'h1);
    src = '0;
    #1 check("R9 still high before edge", 40'(irq), 40'h1);
    @(negedge clk);
    check("R9 request drops after edge", 40'(irq), 40'h0);

    finish_run();
  end
endmodule